// File: doc/BRIEF.md
# Periodic Wake-Up and Reset Timer

This block is an always-running interval timer for a low-power system. It advances on a strobe, `tick_i`, that arrives once per period of a slow oscillator of about 1 ms. The strobe passes through an 8-bit programmable prescaler. The prescaled pulse then drives two separate 8-bit dividers. One divider marks the end of each wake-up interval and the other marks the end of each periodic-reset interval. At the end of an interval a divider sets its sticky flag. The wake-up flag is the wake-up interrupt, and the reset flag is a request for a system reset. After each event the divider reloads by itself and starts the next interval.

Software controls the timer through a write-only register port: a write enable, a 2-bit address and a data byte. It reads back the flags and the effective enables as plain output pins. No stream data enters or leaves the block, so the block has no valid/ready handshake and every pin is plain control or status. No setting of the enables can turn off both outputs. Once the wake-up interrupt is raised, it can only be removed by an acknowledge.

Top module: `pwu_timer`

## Requirements
- R1: After reset both flags are low, the effective wake-up enable is high, and the effective reset enable is low. The prescaler and both divider values reset to 0.
- R2: The prescaler emits one pulse for every P ticks, where P is the value at address 1. A value of 0 means 256.
- R3: With wake-up enabled, the wake-up flag rises on the edge that samples tick number P*Nw after the last restart, where Nw is the value at address 2. It rises again every further P*Nw ticks without any new write.
- R4: With reset enabled, the reset flag rises on tick number P*Nr after the last restart, where Nr is the value at address 3, and it repeats every P*Nr ticks.
- R5: A divider value of 0 divides by 256.
- R6: Address 0 holds the control bits: bit0 is the wake-up enable and bit1 is the reset enable. If both bits are 0, the wake-up path is forced on. `wake_en_o` and `rst_en_o` are never low together.
- R7: While its path is disabled, a flag that is low stays low for any number of ticks.
- R8: Writing 1 to bit4 of address 0 clears the wake-up flag, and writing 1 to bit5 clears the reset flag. Writing 0 to these bits leaves the flags unchanged.
- R9: Once the wake-up flag is set, changing the enables does not lower it. Only an acknowledge lowers it.
- R10: If an event and an acknowledge for the same flag occur in the same cycle, the flag is set after that cycle.
- R11: Writing the prescaler or a divider value restarts that counter from zero. The next event therefore comes a full new interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per slow-oscillator period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 prescaler, 2 wake divider, 3 reset divider |
| wr_data_i | input | 8 | Register write data |
| wake_irq_o | output | 1 | Sticky wake-up flag / interrupt |
| rst_req_o | output | 1 | Sticky periodic-reset flag / reset request |
| wake_en_o | output | 1 | Effective wake-up enable |
| rst_en_o | output | 1 | Effective reset enable |

## Verification
The assertions assume that `tick_i` and `wr_en_i` are single-cycle strobes sampled on the rising clock edge. They also assume that a write addressing a counter is not expected to produce an event in its own cycle. The bench therefore issues ticks only in cycles with no write, except in the deliberate collision of an acknowledge with an event. The random phase limits the prescaler to 1–3 and the dividers to 1–6 so that many intervals elapse. The directed cases cover the divide-by-256 settings and the restart writes.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PRESC = 2'd1,
    REG_WDIV  = 2'd2,
    REG_RDIV  = 2'd3
  } pwu_addr_e;

  localparam int unsigned CTL_WAKE_EN  = 0;
  localparam int unsigned CTL_RST_EN   = 1;
  localparam int unsigned CTL_WAKE_ACK = 4;
  localparam int unsigned CTL_RST_ACK  = 5;

  localparam int unsigned PATH_WAKE = 0;
  localparam int unsigned PATH_RST  = 1;
  localparam int unsigned NUM_PATHS = 2;
endpackage

// File: rtl/pwu_counter.sv
module pwu_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             at_end;

  assign cnt_inc = cnt_q + 1'b1;
  assign at_end  = (cnt_inc == limit_q);
  assign hit_o   = en_i && step_i && !load_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      limit_q <= load_val_i;
      cnt_q   <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= at_end ? '0 : cnt_inc;
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q != '0) |-> (cnt_q < limit_q));

  p_load_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwu_regs.sv
module pwu_regs
  import pwu_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [NUM_PATHS-1:0] hit_i,
  output logic                 presc_load_o,
  output logic [NUM_PATHS-1:0] div_load_o,
  output logic [NUM_PATHS-1:0] en_eff_o,
  output logic [NUM_PATHS-1:0] flag_o
);
  logic                 wake_en_q;
  logic                 rst_en_q;
  logic                 ctl_wr;
  logic [NUM_PATHS-1:0] ack;

  assign ctl_wr       = wr_en_i && (wr_addr_i == REG_CTRL);
  assign presc_load_o = wr_en_i && (wr_addr_i == REG_PRESC);
  assign div_load_o[PATH_WAKE] = wr_en_i && (wr_addr_i == REG_WDIV);
  assign div_load_o[PATH_RST]  = wr_en_i && (wr_addr_i == REG_RDIV);
  assign ack[PATH_WAKE] = ctl_wr && wr_data_i[CTL_WAKE_ACK];
  assign ack[PATH_RST]  = ctl_wr && wr_data_i[CTL_RST_ACK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en_q <= 1'b1;
      rst_en_q  <= 1'b0;
    end else if (ctl_wr) begin
      wake_en_q <= wr_data_i[CTL_WAKE_EN];
      rst_en_q  <= wr_data_i[CTL_RST_EN];
    end
  end

  // an all-off setting falls back to wake-up only
  assign en_eff_o[PATH_WAKE] = wake_en_q || !rst_en_q;
  assign en_eff_o[PATH_RST]  = rst_en_q;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit_i[g]) flag_q <= 1'b1;
      else if (ack[g])   flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[g] |=> flag_o[g]);
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !hit_i[g]) |=> !flag_o[g]);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !ack[g]) |=> flag_o[g]);
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_eff_o[g] && !flag_o[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/pwu_timer.sv
module pwu_timer
  import pwu_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             wake_irq_o,
  output logic             rst_req_o,
  output logic             wake_en_o,
  output logic             rst_en_o
);
  logic                 presc_load;
  logic                 presc_pulse;
  logic [NUM_PATHS-1:0] div_load;
  logic [NUM_PATHS-1:0] en_eff;
  logic [NUM_PATHS-1:0] hit;
  logic [NUM_PATHS-1:0] flag;

  pwu_regs #(.CNT_W(CNT_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .hit_i        (hit),
    .presc_load_o (presc_load),
    .div_load_o   (div_load),
    .en_eff_o     (en_eff),
    .flag_o       (flag)
  );

  pwu_counter #(.CNT_W(CNT_W)) presc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (1'b1),
    .step_i     (tick_i),
    .load_i     (presc_load),
    .load_val_i (wr_data_i),
    .hit_o      (presc_pulse)
  );

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_div
    pwu_counter #(.CNT_W(CNT_W)) div_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_eff[g]),
      .step_i     (presc_pulse),
      .load_i     (div_load[g]),
      .load_val_i (wr_data_i),
      .hit_o      (hit[g])
    );
  end

  assign wake_irq_o = flag[PATH_WAKE];
  assign rst_req_o  = flag[PATH_RST];
  assign wake_en_o  = en_eff[PATH_WAKE];
  assign rst_en_o   = en_eff[PATH_RST];

  p_never_both_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en_o || rst_en_o);

  p_event_needs_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> (presc_pulse && tick_i));
endmodule

// File: tb/pwu_timer_tb_top.sv
module pwu_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wake_irq_o, rst_req_o, wake_en_o, rst_en_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwu_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wake_irq_o(wake_irq_o),
    .rst_req_o(rst_req_o), .wake_en_o(wake_en_o), .rst_en_o(rst_en_o)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 256 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = addr[1:0]; wr_data_i = data[7:0];
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic setup(input int ctl, input int p, input int nw, input int nr);
    wr(0, ctl | 8'h30);
    wr(1, p); wr(2, nw); wr(3, nr);
    wr(0, ctl | 8'h30);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wake flag", wake_irq_o, 0);
    check("R1 reset flag", rst_req_o, 0);
    check("R1 wake enable", wake_en_o, 1);
    check("R1 reset enable", rst_en_o, 0);

    // R2 R3: P=3, Nw=2 -> flag on tick 6
    setup(3, 3, 2, 5);
    ticks(5);
    check("R2 R3 no wake before 6", wake_irq_o, 0);
    ticks(1);
    check("R2 R3 wake at 6", wake_irq_o, 1);
    ticks(4);
    check("R4 no reset before 15", rst_req_o, 0);
    ticks(5);
    check("R4 reset at 15", rst_req_o, 1);

    // R8: ack bits at 0 keep flags, then ack clears
    wr(0, 8'h03);
    check("R8 zero ack keeps wake", wake_irq_o, 1);
    check("R8 zero ack keeps reset", rst_req_o, 1);
    wr(0, 8'h13);
    check("R8 wake ack clears", wake_irq_o, 0);
    check("R8 wake ack spares reset", rst_req_o, 1);
    wr(0, 8'h23);
    check("R8 reset ack clears", rst_req_o, 0);

    // R5: divider 0 -> 256
    setup(1, 1, 0, 1);
    ticks(255);
    check("R5 no wake at 255", wake_irq_o, 0);
    ticks(1);
    check("R5 wake at 256", wake_irq_o, 1);
    // R2: prescaler 0 -> 256
    setup(1, 0, 1, 1);
    ticks(255);
    check("R2 presc 0 no wake at 255", wake_irq_o, 0);
    ticks(1);
    check("R2 presc 0 wake at 256", wake_irq_o, 1);

    // R6 enable decode
    wr(0, 8'h30);
    check("R6 all-off forces wake", wake_en_o, 1);
    check("R6 all-off reset off", rst_en_o, 0);
    wr(0, 8'h02);
    check("R6 reset only wake off", wake_en_o, 0);
    check("R6 reset only reset on", rst_en_o, 1);

    // R7: wake disabled stays low, reset still fires
    setup(2, 1, 2, 3);
    ticks(6);
    check("R7 disabled wake stays low", wake_irq_o, 0);
    check("R7 reset path fires", rst_req_o, 1);

    // R9: wake flag survives disabling
    setup(1, 1, 1, 1);
    ticks(1);
    check("R9 wake set", wake_irq_o, 1);
    wr(0, 8'h02);
    check("R9 wake not masked", wake_irq_o, 1);
    wr(0, 8'h01);
    check("R9 wake still set", wake_irq_o, 1);

    // R10: event and ack together
    setup(1, 1, 1, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h11;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R10 event beats ack", wake_irq_o, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h11;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R10 event beats ack on set flag", wake_irq_o, 1);

    // R11: rewriting restarts counters
    setup(1, 1, 4, 1);
    ticks(2);
    wr(2, 4);
    ticks(3);
    check("R11 divider restart no early wake", wake_irq_o, 0);
    ticks(1);
    check("R11 divider restart wake", wake_irq_o, 1);
    setup(1, 4, 1, 1);
    ticks(3);
    wr(1, 4);
    ticks(3);
    check("R11 presc restart no early wake", wake_irq_o, 0);
    ticks(1);
    check("R11 presc restart wake", wake_irq_o, 1);

    // random phase: R3 R4 auto reload with random acks
    for (int it = 0; it < 6; it++) begin
      int p, nw, nr;
      bit ew, er;
      p  = $urandom_range(1, 3);
      nw = $urandom_range(1, 6);
      nr = $urandom_range(1, 6);
      setup(3, p, nw, nr);
      ew = 0; er = 0;
      for (int t = 1; t <= 40; t++) begin
        ticks(1);
        if (t % (eff(p) * eff(nw)) == 0) ew = 1;
        if (t % (eff(p) * eff(nr)) == 0) er = 1;
        check("R3 random wake", wake_irq_o, ew);
        check("R4 random reset", rst_req_o, er);
        if ($urandom_range(0, 4) == 0) begin
          wr(0, 8'h33);
          ew = 0; er = 0;
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule